// File: doc/BRIEF.md
# Sparse-Aware Output-Stationary Multiply-Accumulate Grid

This block is a two-dimensional grid of processing elements for the convolution layers of an inference engine. Each element owns one output value and accumulates into it where it sits. Activations enter on the left edge, one per row, and move right. Weights enter on the top edge, one per column, and move down. The array delays row `r` by `r` cycles and column `c` by `c` cycles itself. The caller therefore presents activation column `k` of the tile together with weight row `k` in the same cycle.

Before each multiply-accumulate, an element checks the pair of operands that reaches it. If either operand is zero, the element leaves its accumulator and multiplier idle and reports a skip. The operands still move on to its neighbours. A global counter adds up these skips.

A tile-start tag travels with the activations. When the tag reaches an element, the element moves its finished sum into a result register and starts the next sum from zero. This lets the next tile stream in right behind the current one. The result registers form one shift chain per row, and a drain command moves the chain one column towards the right edge.

Top module: `mac_array`

## Requirements
- R1: While `rst_n` is low at a clock edge, every result register, every accumulator and `skip_count` become zero.
- R2: Suppose column `k` of activation tile A is driven on `act_data` (row `r` in bits `r*DATA_W` upward) and row `k` of weight tile W on `wgt_data` (column `c` in bits `c*DATA_W` upward), with both valid bits high, for k = 0..K-1. Then the result for element (r,c) is the sum over k of A[r][k]·W[k][c]. All operands are signed two's-complement values.
- R3: Each accumulation step saturates to the largest or smallest signed `ACC_W`-bit value. The clamp is applied after every step, in order of k, so later steps of the same sum start from the clamped value.
- R4: A valid pair in which either operand is zero leaves the accumulator unchanged and adds exactly one to `skip_count`. A pair with both operands non-zero never adds to it.
- R5: An element that skips still passes both operands on to its neighbours, so the results of elements further along are unaffected.
- R6: `tile_start` high with the first pair of a tile marks a tile boundary. When the mark reaches an element, the element copies its current sum to its result register and starts from that pair's product. A mark with both valid bits low copies the sum, zeroes the accumulator and does not count as a skip.
- R7: The next tile may start in the cycle after the previous tile's last pair. The previous tile's results can be drained while the next tile is still accumulating.
- R8: `res_out` row `r` shows the result register of column `COLS-1`. Each cycle with `drain` high moves every result one column to the right and fills column 0 with zero. After `COLS` drains, `res_out` is all zero.
- R9: A single cycle of `clear` zeroes every accumulator, every result register and `skip_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Zeroes sums, results and skip counter in one cycle |
| drain | input | 1 | Shifts the result registers one column to the right |
| act_valid | input | 1 | The activation column on `act_data` is valid |
| tile_start | input | 1 | Tile-boundary tag that travels with the activations |
| act_data | input | ROWS*DATA_W | One signed activation per row |
| wgt_valid | input | 1 | The weight row on `wgt_data` is valid |
| wgt_data | input | COLS*DATA_W | One signed weight per column |
| res_out | output | ROWS*ACC_W | Result registers of the rightmost column, one per row |
| skip_count | output | CNT_W | Number of suppressed multiply-accumulates since reset or clear |

## Verification
Random tiles with about 70, 90 and 50 percent zeros are compared element by element with a saturating software matrix product. Together with the skip count, these tiles separate a correct zero test from one that skips too often or too rarely, and they show whether skipped elements still forward operands. A dense tile and a tile with no zeros at all separate a skip counter that counts skips from one that counts all valid pairs. A tile that drives one sum past full scale and then back down tells a per-step clamp apart from a clamp applied only at the end. Two tiles sent back to back with a drain during the second show whether the boundary tag hands over the sums correctly. A clear in mid-state, with the results read back afterwards, confirms that clear reaches every register.

// File: rtl/mac_pkg.sv
// Shared types for the multiply-accumulate grid.
// Assumes nothing beyond standard SystemVerilog.
package mac_pkg;

    // What one processing element does with the operands arriving this cycle.
    typedef enum logic [1:0] {
        PE_IDLE = 2'd0,   // no valid pair
        PE_MAC  = 2'd1,   // both operands non-zero: accumulate
        PE_SKIP = 2'd2    // a zero operand: accumulator untouched
    } pe_act_e;

endpackage

// File: rtl/mac_skew.sv
// Fixed-depth delay line used to stagger operands at the array edge.
// DEPTH of zero gives a plain wire. Assumes W >= 1.
module mac_skew #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] stage [DEPTH];

            // Shift the operand one stage per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
                end else begin
                    stage[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
                end
            end

            assign q = stage[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/mac_pe.sv
// One processing element: it holds its own sum (output-stationary),
// forwards activation, weight and tag through registers, and skips the
// multiply-accumulate when either operand is zero. The sum saturates.
// Assumes ACC_W >= 2*DATA_W.
module mac_pe
    import mac_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              drain,
    input  logic [DATA_W-1:0] a_i,
    input  logic              av_i,
    input  logic              st_i,
    input  logic [DATA_W-1:0] w_i,
    input  logic              wv_i,
    input  logic [ACC_W-1:0]  res_left_i,
    output logic [DATA_W-1:0] a_o,
    output logic              av_o,
    output logic              st_o,
    output logic [DATA_W-1:0] w_o,
    output logic              wv_o,
    output logic [ACC_W-1:0]  res_o,
    output logic              mac_o,
    output logic              skip_o
);

    localparam int PROD_W = 2 * DATA_W;
    localparam int SUM_W  = ACC_W + 1;
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    pe_act_e           act;
    logic [PROD_W-1:0] prod;
    logic [SUM_W-1:0]  sum;
    logic [ACC_W-1:0]  base;
    logic [ACC_W-1:0]  acc_d;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  res_q;

    // Classify the arriving pair: idle, real MAC or skipped MAC.
    always_comb begin
        if (av_i && wv_i) begin
            act = (a_i != '0 && w_i != '0) ? PE_MAC : PE_SKIP;
        end else begin
            act = PE_IDLE;
        end
    end

    // Next sum: restart at a tile boundary, then saturating add on a MAC.
    always_comb begin
        base  = st_i ? '0 : acc_q;
        prod  = PROD_W'($signed(a_i) * $signed(w_i));
        sum   = {base[ACC_W-1], base} + {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod};
        acc_d = base;
        if (act == PE_MAC) begin
            if (sum[SUM_W-1] != sum[SUM_W-2]) begin
                acc_d = sum[SUM_W-1] ? ACC_MIN : ACC_MAX;
            end else begin
                acc_d = sum[ACC_W-1:0];
            end
        end
    end

    // Forward the operands and tag to the right and downward neighbours.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_o  <= '0;
            av_o <= 1'b0;
            st_o <= 1'b0;
            w_o  <= '0;
            wv_o <= 1'b0;
        end else begin
            a_o  <= a_i;
            av_o <= av_i;
            st_o <= st_i;
            w_o  <= w_i;
            wv_o <= wv_i;
        end
    end

    // Hold the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // Result register: capture at a tile boundary, otherwise shift on drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (clear) begin
            res_q <= '0;
        end else if (st_i) begin
            res_q <= acc_q;
        end else if (drain) begin
            res_q <= res_left_i;
        end
    end

    assign res_o  = res_q;
    assign mac_o  = (act == PE_MAC);
    assign skip_o = (act == PE_SKIP);

endmodule

// File: rtl/mac_skip_count.sv
// Adds up the skip flags of all elements every cycle into a wide counter.
// Assumes CNT_W is at least the width of the per-cycle population count.
module mac_skip_count #(
    parameter int N     = 256,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [N-1:0]     hits,
    output logic [CNT_W-1:0] count
);

    localparam int PC_W = $clog2(N + 1);

    logic [PC_W-1:0]  pc;
    logic [CNT_W-1:0] count_q;

    // Population count of this cycle's skip flags.
    always_comb begin
        pc = '0;
        for (int i = 0; i < N; i++) pc = pc + PC_W'(hits[i]);
    end

    // Accumulate the skips, zeroed by reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + CNT_W'(pc);
        end
    end

    assign count = count_q;

endmodule

// File: rtl/mac_array.sv
// Top of the grid. It staggers the operands at the edges, instantiates
// ROWS x COLS processing elements, chains their result registers
// towards the right edge and counts the skipped operations.
// Assumes ACC_W >= 2*DATA_W. Drain must not overlap a boundary wave.
module mac_array #(
    parameter int ROWS   = 16,
    parameter int COLS   = 16,
    parameter int DATA_W = 8,
    parameter int ACC_W  = 24,
    parameter int CNT_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   drain,
    input  logic                   act_valid,
    input  logic                   tile_start,
    input  logic [ROWS*DATA_W-1:0] act_data,
    input  logic                   wgt_valid,
    input  logic [COLS*DATA_W-1:0] wgt_data,
    output logic [ROWS*ACC_W-1:0]  res_out,
    output logic [CNT_W-1:0]       skip_count
);

    localparam int N_PE  = ROWS * COLS;
    localparam int ROW_W = DATA_W + 2;
    localparam int COL_W = DATA_W + 1;

    logic [DATA_W-1:0] a_h   [ROWS][COLS+1];
    logic              av_h  [ROWS][COLS+1];
    logic              st_h  [ROWS][COLS+1];
    logic [DATA_W-1:0] w_v   [ROWS+1][COLS];
    logic              wv_v  [ROWS+1][COLS];
    logic [ACC_W-1:0]  res_h [ROWS][COLS+1];
    logic [N_PE-1:0]   skip_vec;
    logic [N_PE-1:0]   mac_vec;
    logic              edge_unused;

    genvar r, c;
    generate
        // Left edge: delay row r by r cycles.
        for (r = 0; r < ROWS; r++) begin : g_row_skew
            logic [ROW_W-1:0] row_q;
            mac_skew #(.W(ROW_W), .DEPTH(r)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .d     ({tile_start, act_valid, act_data[r*DATA_W +: DATA_W]}),
                .q     (row_q)
            );
            assign a_h[r][0]   = row_q[DATA_W-1:0];
            assign av_h[r][0]  = row_q[DATA_W];
            assign st_h[r][0]  = row_q[DATA_W+1];
            assign res_h[r][0] = '0;
            assign res_out[r*ACC_W +: ACC_W] = res_h[r][COLS];
        end

        // Top edge: delay column c by c cycles.
        for (c = 0; c < COLS; c++) begin : g_col_skew
            logic [COL_W-1:0] col_q;
            mac_skew #(.W(COL_W), .DEPTH(c)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .d     ({wgt_valid, wgt_data[c*DATA_W +: DATA_W]}),
                .q     (col_q)
            );
            assign w_v[0][c]  = col_q[DATA_W-1:0];
            assign wv_v[0][c] = col_q[DATA_W];
        end

        // The grid of processing elements.
        for (r = 0; r < ROWS; r++) begin : g_r
            for (c = 0; c < COLS; c++) begin : g_c
                mac_pe #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_pe (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .clear      (clear),
                    .drain      (drain),
                    .a_i        (a_h[r][c]),
                    .av_i       (av_h[r][c]),
                    .st_i       (st_h[r][c]),
                    .w_i        (w_v[r][c]),
                    .wv_i       (wv_v[r][c]),
                    .res_left_i (res_h[r][c]),
                    .a_o        (a_h[r][c+1]),
                    .av_o       (av_h[r][c+1]),
                    .st_o       (st_h[r][c+1]),
                    .w_o        (w_v[r+1][c]),
                    .wv_o       (wv_v[r+1][c]),
                    .res_o      (res_h[r][c+1]),
                    .mac_o      (mac_vec[r*COLS+c]),
                    .skip_o     (skip_vec[r*COLS+c])
                );
            end
        end
    endgenerate

    // Fold the operands that leave the far edges; they have no consumer.
    always_comb begin
        edge_unused = 1'b0;
        for (int i = 0; i < ROWS; i++) begin
            edge_unused = edge_unused ^ (^a_h[i][COLS]) ^ av_h[i][COLS] ^ st_h[i][COLS];
        end
        for (int j = 0; j < COLS; j++) begin
            edge_unused = edge_unused ^ (^w_v[ROWS][j]) ^ wv_v[ROWS][j];
        end
    end

    mac_skip_count #(.N(N_PE), .CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .hits  (skip_vec),
        .count (skip_count)
    );

endmodule

// File: rtl/mac_array_chk.sv
// Checker for mac_array: properties on the reset, clear and skip-count
// behaviour. It is attached to every mac_array instance through bind.
module mac_array_chk #(
    parameter int N     = 256,
    parameter int CNT_W = 32,
    parameter int OUT_W = 384
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic [N-1:0]     skip_vec,
    input logic [N-1:0]     mac_vec,
    input logic [OUT_W-1:0] res_out,
    input logic [CNT_W-1:0] skip_count
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (skip_count == '0 && res_out == '0));

    // R9
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (skip_count == '0 && res_out == '0));

    // R4
    skip_mac_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_vec & mac_vec) == '0);

    // R4
    skip_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clear) |=>
        skip_count == $past(skip_count) + CNT_W'($past($countones(skip_vec))));

endmodule

bind mac_array mac_array_chk #(
    .N     (ROWS*COLS),
    .CNT_W (CNT_W),
    .OUT_W (ROWS*ACC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .skip_vec   (skip_vec),
    .mac_vec    (mac_vec),
    .res_out    (res_out),
    .skip_count (skip_count)
);

// File: tb/mac_array_tb.sv
module mac_array_tb;

    localparam int R    = 3;
    localparam int C    = 4;
    localparam int DW   = 8;
    localparam int AW   = 16;
    localparam int CW   = 32;
    localparam int KMAX = 12;
    localparam int AMAX = 32767;
    localparam int AMIN = -32768;

    typedef int mat_t [R][C];

    // Table of random tiles: seed, zero percentage, depth K.
    localparam int TBL [5][3] = '{
        '{11, 70, 4},
        '{29, 70, 8},
        '{47, 90, 6},
        '{83, 50, 12},
        '{5,  0,  3}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clear = 1'b0;
    logic            drain = 1'b0;
    logic            act_valid = 1'b0;
    logic            tile_start = 1'b0;
    logic [R*DW-1:0] act_data = '0;
    logic            wgt_valid = 1'b0;
    logic [C*DW-1:0] wgt_data = '0;
    logic [R*AW-1:0] res_out;
    logic [CW-1:0]   skip_count;

    int n_chk  = 0;
    int n_fail = 0;
    int rng    = 1;
    int exp_skip = 0;
    int A [R][KMAX];
    int W [KMAX][C];
    mat_t refm;
    mat_t refa;
    mat_t zero_m;

    always #4 clk = ~clk;

    mac_array #(.ROWS(R), .COLS(C), .DATA_W(DW), .ACC_W(AW), .CNT_W(CW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .drain      (drain),
        .act_valid  (act_valid),
        .tile_start (tile_start),
        .act_data   (act_data),
        .wgt_valid  (wgt_valid),
        .wgt_data   (wgt_data),
        .res_out    (res_out),
        .skip_count (skip_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic int rnd();
        rng = rng * 1103515245 + 12345;
        return (rng >>> 16) & 32'h7fff;
    endfunction

    // Random sparse tile of depth kk.
    task automatic gen_tile(input int seed, input int zpct, input int kk);
        rng = seed;
        for (int r = 0; r < R; r++)
            for (int k = 0; k < kk; k++)
                A[r][k] = (rnd() % 100 < zpct) ? 0 : (rnd() % 256) - 128;
        for (int k = 0; k < kk; k++)
            for (int c = 0; c < C; c++)
                W[k][c] = (rnd() % 100 < zpct) ? 0 : (rnd() % 256) - 128;
    endtask

    // Saturating reference product and expected skip count (R2, R3, R4).
    task automatic compute_ref(input int kk);
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                int s = 0;
                for (int k = 0; k < kk; k++) begin
                    if (A[r][k] == 0 || W[k][c] == 0) exp_skip++;
                    else begin
                        s = s + A[r][k] * W[k][c];
                        if (s > AMAX) s = AMAX;
                        if (s < AMIN) s = AMIN;
                    end
                end
                refm[r][c] = s;
            end
    endtask

    task automatic inject(input int kk);
        for (int k = 0; k < kk; k++) begin
            @(negedge clk);
            act_valid  = 1'b1;
            wgt_valid  = 1'b1;
            tile_start = (k == 0);
            for (int r = 0; r < R; r++) act_data[r*DW +: DW] = A[r][k][DW-1:0];
            for (int c = 0; c < C; c++) wgt_data[c*DW +: DW] = W[k][c][DW-1:0];
        end
    endtask

    // Boundary mark without operands (R6), then wait for the wave.
    task automatic flush_wait();
        @(negedge clk);
        act_valid  = 1'b0;
        wgt_valid  = 1'b0;
        tile_start = 1'b1;
        @(negedge clk);
        tile_start = 1'b0;
        repeat (R + C + 2) @(negedge clk);
    endtask

    // Read the right edge, drain, repeat for every column (R8).
    task automatic read_drain(input mat_t m, input string req);
        for (int j = C - 1; j >= 0; j--) begin
            for (int r = 0; r < R; r++)
                chk(req, int'($signed(res_out[r*AW +: AW])), m[r][j]);
            drain = 1'b1;
            @(negedge clk);
            drain = 1'b0;
        end
        chk("R8 zero fill", int'(res_out == '0), 1);
    endtask

    initial begin
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) zero_m[r][c] = 0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 results", int'(res_out == '0), 1);
        chk("R1 skip_count", int'(skip_count), 0);
        rst_n = 1'b1;

        // R2 R4 R5: random sparse tiles from the table
        foreach (TBL[i]) begin
            gen_tile(TBL[i][0], TBL[i][1], TBL[i][2]);
            compute_ref(TBL[i][2]);
            inject(TBL[i][2]);
            flush_wait();
            chk("R4 skip_count", int'(skip_count), exp_skip);
            read_drain(refm, "R2 R5 product");
        end

        // R3: per-step clamp, then recovery below the ceiling
        for (int r = 0; r < R; r++)
            for (int k = 0; k < 4; k++) A[r][k] = (k == 3) ? -128 : ((r == 1) ? -128 : 127);
        for (int k = 0; k < 4; k++)
            for (int c = 0; c < C; c++) W[k][c] = (c == 3) ? -128 : 127;
        compute_ref(4);
        chk("R3 reference", refm[0][0], 16511);
        inject(4);
        flush_wait();
        read_drain(refm, "R3 saturation");

        // R7: back-to-back tiles, drain of the first during the second
        gen_tile(101, 70, 6);
        compute_ref(6);
        refa = refm;
        inject(6);
        gen_tile(202, 70, 12);
        compute_ref(12);
        fork
            inject(12);
            begin
                repeat (R + C + 1) @(negedge clk);
                read_drain(refa, "R7 first tile");
            end
        join
        flush_wait();
        chk("R7 skip_count", int'(skip_count), exp_skip);
        read_drain(refm, "R7 second tile");

        // R9: clear after an undrained tile
        gen_tile(7, 60, 5);
        compute_ref(5);
        inject(5);
        flush_wait();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        exp_skip = 0;
        chk("R9 skip_count", int'(skip_count), 0);
        read_drain(zero_m, "R9 results");

        // R6: boundary mark alone counts nothing and captures zero
        flush_wait();
        chk("R6 mark no skip", int'(skip_count), 0);
        chk("R6 mark result", int'(res_out == '0), 1);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule